// File: doc/BRIEF.md
# Load-Use Stall Controller

This block sits beside the decode stage of an in-order five-stage pipeline. It handles the one read-after-write case that result forwarding cannot cover. An instruction in decode wants a register that a load, one stage ahead in execute, has not yet fetched from data memory. The controller compares the load's destination index with both source indices of the decoding instruction. On a match it holds the program counter and the fetch/decode register for one cycle. It also drives a select that zeroes the control bundle entering the decode/execute register. That zeroed bundle moves down the pipe as a bubble that writes neither the register file nor memory. One cycle later the held instruction decodes again, and the loaded value can then be forwarded from the memory/write-back register.

The decision is purely combinational, so it reaches the PC and pipeline register enables in the same cycle as the compare. A taken-branch request can turn the fetch/decode contents into a no-op when the `FLUSH_EN` option is built in. It takes priority over the freeze, so the redirected fetch is never held back. A second build option, `ZERO_REG_GUARD`, tells the unit whether register index zero is hard-wired. When it is, a load that targets index zero never stalls. Clock and reset serve only the in-module property checks.

Top module: `lu_hazard_unit`

## Requirements
- R1: When `ex_is_load` is 1, `branch_taken` is 0 and `ex_dst` equals `id_src_a`, the unit stalls in that same cycle: `pc_we`=0, `ifid_we`=0 and `ctrl_zero_sel`=1. Index zero is excluded when `ZERO_REG_GUARD`=1.
- R2: The same stall occurs when `ex_dst` equals `id_src_b`. It also occurs when both sources match.
- R3: When `ex_is_load` is 0, no stall is signalled, whatever the indices are. Once the injected bubble (not a load) occupies execute, the stall therefore ends after exactly one cycle.
- R4: With no branch request and no matching load, the outputs are `pc_we`=1, `ifid_we`=1, `ctrl_zero_sel`=0 and `ifid_flush`=0.
- R5: With `ZERO_REG_GUARD`=1, a load whose `ex_dst` is 0 never stalls, even when a source index is also 0.
- R6: With `ZERO_REG_GUARD`=0, index 0 is compared like any other index, so a load to 0 with a source of 0 stalls.
- R7: With `FLUSH_EN`=1, `branch_taken`=1 gives `ifid_flush`=1 together with `pc_we`=1 and `ifid_we`=1, even while a load-use match is present.
- R8: `ctrl_zero_sel` follows the load-use match alone. A branch request neither sets it nor clears it.
- R9: With `FLUSH_EN`=0, `ifid_flush` stays 0 and `branch_taken` has no effect on any output.
- R10: `pc_we` and `ifid_we` are equal in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the property checks |
| rst | input | 1 | Synchronous active-high reset, disables the checks |
| ex_is_load | input | 1 | Instruction in execute reads data memory |
| ex_dst | input | REG_W | Destination register index of the instruction in execute |
| id_src_a | input | REG_W | First source register index of the instruction in decode |
| id_src_b | input | REG_W | Second source register index of the instruction in decode |
| branch_taken | input | 1 | Taken-branch redirect request |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| ctrl_zero_sel | output | 1 | Selects an all-zero control bundle into the decode/execute register |
| ifid_flush | output | 1 | Turns the fetch/decode contents into a no-op |

## Verification
The bench builds two copies side by side with the same stimulus. `dut` uses the defaults (`REG_W`=5, `ZERO_REG_GUARD`=1, `FLUSH_EN`=1). `dut_nf` uses `ZERO_REG_GUARD`=0 and `FLUSH_EN`=0. With this pairing one load to register 0 exercises both the guarded and the unguarded compare. One branch request, made with and without a coincident load-use match, shows flush priority in one copy and a branch-blind unit in the other. Index 31 covers the top of the 5-bit index range.

// File: rtl/lu_pkg.sv
package lu_pkg;

  // Number of source operands compared per decoding instruction
  localparam int unsigned NSRC = 2;

  // Pipeline steering bundle produced by the unit
  typedef struct packed {
    logic pc_we;
    logic ifid_we;
    logic ctrl_zero_sel;
    logic ifid_flush;
  } lu_ctrl_t;

endpackage

// File: rtl/lu_reg_match.sv
module lu_reg_match #(
  parameter int unsigned REG_W          = 5,
  parameter bit          ZERO_REG_GUARD = 1'b1
) (
  input  logic [REG_W-1:0] producer,
  input  logic [REG_W-1:0] consumer,
  output logic             hit
);

  logic same_idx;

  assign same_idx = (producer == consumer);

  generate
    if (ZERO_REG_GUARD) begin : g_guard
      // Index zero is hard-wired and never carries a pending value
      assign hit = same_idx && (producer != '0);
    end else begin : g_plain
      assign hit = same_idx;
    end
  endgenerate

endmodule

// File: rtl/lu_stall_decide.sv
module lu_stall_decide
  import lu_pkg::*;
#(
  parameter int unsigned REG_W          = 5,
  parameter bit          ZERO_REG_GUARD = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ex_is_load,
  input  logic [REG_W-1:0]           ex_dst,
  input  logic [NSRC-1:0][REG_W-1:0] id_srcs,
  output logic                       stall
);

  logic [NSRC-1:0] src_hit;

  generate
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      lu_reg_match #(
        .REG_W         (REG_W),
        .ZERO_REG_GUARD(ZERO_REG_GUARD)
      ) u_match (
        .producer(ex_dst),
        .consumer(id_srcs[s]),
        .hit     (src_hit[s])
      );
    end
  endgenerate

  assign stall = ex_is_load && (|src_hit);

  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    !ex_is_load |-> !stall); // R3

  generate
    if (ZERO_REG_GUARD) begin : g_zero_chk
      AST_ZERO_DST_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        (ex_dst == '0) |-> !stall); // R5
    end else begin : g_nozero_chk
      AST_ZERO_DST_STALLS: assert property (@(posedge clk) disable iff (rst)
        (ex_is_load && ex_dst == '0 && id_srcs[0] == '0) |-> stall); // R6
    end
  endgenerate

endmodule

// File: rtl/lu_flush_ctrl.sv
module lu_flush_ctrl
  import lu_pkg::*;
#(
  parameter bit FLUSH_EN = 1'b1
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     stall,
  input  logic     branch_taken,
  output lu_ctrl_t ctrl
);

  logic flush_eff;

  generate
    if (FLUSH_EN) begin : g_flush
      assign flush_eff = branch_taken;
    end else begin : g_noflush
      assign flush_eff = 1'b0;
    end
  endgenerate

  // A redirect overrides the freeze so the new fetch address is taken
  always_comb begin
    ctrl.pc_we         = !stall || flush_eff;
    ctrl.ifid_we       = !stall || flush_eff;
    ctrl.ctrl_zero_sel = stall;
    ctrl.ifid_flush    = flush_eff;
  end

  AST_WE_PAIRED: assert property (@(posedge clk) disable iff (rst)
    ctrl.pc_we == ctrl.ifid_we); // R10

  generate
    if (FLUSH_EN) begin : g_flush_chk
      AST_FLUSH_WINS: assert property (@(posedge clk) disable iff (rst)
        branch_taken |-> (ctrl.ifid_flush && ctrl.pc_we && ctrl.ifid_we)); // R7
    end else begin : g_noflush_chk
      AST_FLUSH_ABSENT: assert property (@(posedge clk) disable iff (rst)
        !ctrl.ifid_flush); // R9
      AST_BRANCH_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (branch_taken && stall) |-> (!ctrl.pc_we && !ctrl.ifid_we)); // R9
    end
  endgenerate

endmodule

// File: rtl/lu_hazard_unit.sv
module lu_hazard_unit
  import lu_pkg::*;
#(
  parameter int unsigned REG_W          = 5,
  parameter bit          ZERO_REG_GUARD = 1'b1,
  parameter bit          FLUSH_EN       = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] ex_dst,
  input  logic [REG_W-1:0] id_src_a,
  input  logic [REG_W-1:0] id_src_b,
  input  logic             branch_taken,
  output logic             pc_we,
  output logic             ifid_we,
  output logic             ctrl_zero_sel,
  output logic             ifid_flush
);

  logic [NSRC-1:0][REG_W-1:0] srcs;
  logic                       stall;
  lu_ctrl_t                   ctrl;

  assign srcs[0] = id_src_a;
  assign srcs[1] = id_src_b;

  lu_stall_decide #(
    .REG_W         (REG_W),
    .ZERO_REG_GUARD(ZERO_REG_GUARD)
  ) u_decide (
    .clk       (clk),
    .rst       (rst),
    .ex_is_load(ex_is_load),
    .ex_dst    (ex_dst),
    .id_srcs   (srcs),
    .stall     (stall)
  );

  lu_flush_ctrl #(
    .FLUSH_EN(FLUSH_EN)
  ) u_flush (
    .clk         (clk),
    .rst         (rst),
    .stall       (stall),
    .branch_taken(branch_taken),
    .ctrl        (ctrl)
  );

  assign pc_we         = ctrl.pc_we;
  assign ifid_we       = ctrl.ifid_we;
  assign ctrl_zero_sel = ctrl.ctrl_zero_sel;
  assign ifid_flush    = ctrl.ifid_flush;

  AST_SRC_A_STALL: assert property (@(posedge clk) disable iff (rst)
    (ex_is_load && !branch_taken && ex_dst == id_src_a &&
     (!ZERO_REG_GUARD || ex_dst != '0)) |-> (!pc_we && !ifid_we && ctrl_zero_sel)); // R1

  AST_SRC_B_STALL: assert property (@(posedge clk) disable iff (rst)
    (ex_is_load && !branch_taken && ex_dst == id_src_b &&
     (!ZERO_REG_GUARD || ex_dst != '0)) |-> (!pc_we && !ifid_we && ctrl_zero_sel)); // R2

  AST_BUBBLE_UNDER_BRANCH: assert property (@(posedge clk) disable iff (rst)
    (branch_taken && ex_is_load && ex_dst == id_src_a &&
     (!ZERO_REG_GUARD || ex_dst != '0)) |-> ctrl_zero_sel); // R8

endmodule

// File: tb/tb_lu_hazard_unit.sv
module tb_lu_hazard_unit;

  localparam int unsigned REG_W = 5;

  typedef struct {
    logic  pc_we;
    logic  sel;
    logic  flush;
    logic  nf_pc_we;
    logic  nf_sel;
    string tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ex_is_load = 1'b0;
  logic [REG_W-1:0] ex_dst = '0;
  logic [REG_W-1:0] id_src_a = '0;
  logic [REG_W-1:0] id_src_b = '0;
  logic             branch_taken = 1'b0;

  logic pc_we, ifid_we, ctrl_zero_sel, ifid_flush;
  logic nf_pc_we, nf_ifid_we, nf_sel, nf_flush;

  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;
  exp_t q[$];

  always #2 clk = ~clk;

  lu_hazard_unit #(.REG_W(REG_W), .ZERO_REG_GUARD(1'b1), .FLUSH_EN(1'b1)) dut (
    .clk(clk), .rst(rst), .ex_is_load(ex_is_load), .ex_dst(ex_dst),
    .id_src_a(id_src_a), .id_src_b(id_src_b), .branch_taken(branch_taken),
    .pc_we(pc_we), .ifid_we(ifid_we), .ctrl_zero_sel(ctrl_zero_sel),
    .ifid_flush(ifid_flush)
  );

  lu_hazard_unit #(.REG_W(REG_W), .ZERO_REG_GUARD(1'b0), .FLUSH_EN(1'b0)) dut_nf (
    .clk(clk), .rst(rst), .ex_is_load(ex_is_load), .ex_dst(ex_dst),
    .id_src_a(id_src_a), .id_src_b(id_src_b), .branch_taken(branch_taken),
    .pc_we(nf_pc_we), .ifid_we(nf_ifid_we), .ctrl_zero_sel(nf_sel),
    .ifid_flush(nf_flush)
  );

  task automatic drive(input logic ld, input int dst, input int a, input int b,
                       input logic br, input logic e_we, input logic e_sel,
                       input logic e_fl, input logic e_nf_we, input logic e_nf_sel,
                       input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    ex_is_load   = ld;
    ex_dst       = REG_W'(dst);
    id_src_a     = REG_W'(a);
    id_src_b     = REG_W'(b);
    branch_taken = br;
    e.pc_we    = e_we;
    e.sel      = e_sel;
    e.flush    = e_fl;
    e.nf_pc_we = e_nf_we;
    e.nf_sel   = e_nf_sel;
    e.tag      = tag;
    q.push_back(e);
  endtask

  // Monitor: compare at the falling edge, away from the edge inputs change on
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() != 0) begin
        exp_t e;
        e = q.pop_front();
        n_tests++;
        if ({pc_we, ifid_we, ctrl_zero_sel, ifid_flush} !==
            {e.pc_we, e.pc_we, e.sel, e.flush}) begin
          n_fail++;
          $display("FAIL %s dut: pc_we/ifid_we/sel/flush got %b%b%b%b exp %b%b%b%b",
                   e.tag, pc_we, ifid_we, ctrl_zero_sel, ifid_flush,
                   e.pc_we, e.pc_we, e.sel, e.flush);
        end
        n_tests++;
        if ({nf_pc_we, nf_ifid_we, nf_sel, nf_flush} !==
            {e.nf_pc_we, e.nf_pc_we, e.nf_sel, 1'b0}) begin
          n_fail++;
          $display("FAIL %s dut_nf: pc_we/ifid_we/sel/flush got %b%b%b%b exp %b%b%b0",
                   e.tag, nf_pc_we, nf_ifid_we, nf_sel, nf_flush,
                   e.nf_pc_we, e.nf_pc_we, e.nf_sel);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // Reset state: no load in execute, so free-running enables (R4)
    drive(1'b0, 0, 0, 0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R4 reset");
    drive(1'b0, 0, 0, 0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R4 reset");
    rst = 1'b0;
    drive(1'b1, 3, 3, 7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R1 src_a match");
    drive(1'b1, 9, 1, 9, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R2 src_b match");
    drive(1'b1, 9, 9, 9, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R2 both match");
    drive(1'b0, 9, 9, 9, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R3 no load");
    // Load-use pair, then the bubble occupies execute: single stall cycle
    drive(1'b1, 4, 4, 2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R1 pair stall");
    drive(1'b0, 0, 4, 2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R3 stall clears");
    drive(1'b1, 0, 0, 0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R5 R6 dst zero");
    drive(1'b1, 5, 6, 7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R4 load no match");
    drive(1'b0, 1, 2, 3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R7 R9 branch only");
    drive(1'b1, 2, 2, 8, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R7 R8 R9 branch+hazard");
    drive(1'b1, 31, 30, 31, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R2 R10 top index");
    drive(1'b0, 31, 31, 31, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R10 idle");
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule